// File: doc/BRIEF.md
# Clause Issue Controller

This block sequences a shader execution pipeline in clauses: short runs of instructions that are scheduled as one unit and never interleaved with other work. A clause opens with a header beat that names a set of load slots. The block holds the clause back until every named slot has completed. It then streams the clause's instructions toward the arithmetic datapath. Loads and stores are steered to the memory request port instead. A load takes a slot number that its completion later returns. Completions may come back in any order.

Memory operations, whose latency is unknown, are legal only as the first or the final instruction of a clause. One found anywhere else is dropped and flagged. Main register writes made inside a clause are held in a shadow buffer. The architectural copy changes all at once, in the cycle after the final instruction is accepted. Bypass temporaries live only for the span of one clause. Reading a temporary that the current clause has not yet written raises an error pulse.

All three data ports use valid/ready. A beat moves on a cycle when both signals are high at the rising clock edge. A valid source holds its beat stable until it is taken. The controller back-pressures the instruction stream whenever the port that a beat is routed to is not ready.

Top module: `clause_issue_ctrl`

## Requirements
- R1: A header is accepted only while no clause is open (`hdr_ready` high only when idle). From header acceptance until the final instruction is taken, `hdr_ready` stays low.
- R2: After a header is accepted, `ins_ready` stays low while any slot set in `hdr_wait` is outstanding. If the last such slot clears at edge E, `ins_ready` can first be high in the cycle after edge E+1. With an empty mask, that cycle is the one after the cycle following header acceptance.
- R3: A completion (`cmp_valid` with `cmp_slot`) clears only the slot it names. Slots may complete in any order.
- R4: Operation codes are 0 = arithmetic, 1 = load, 2 = store, and 3 = arithmetic. A load gets the lowest-numbered free slot, shown on `ls_slot` with `ls_load`=1. While all slots are outstanding, a load waits with `ls_valid` low. A store is issued with `ls_load`=0 and takes no slot.
- R5: A load or store that is neither the first instruction of its clause nor marked last is accepted and dropped. It appears on no output port, and `err_place` is high in the following cycle.
- R6: An arithmetic instruction that reads a temporary not yet written in the current clause sets `err_temp` in the following cycle. All temporaries become invalid when a clause ends.
- R7: Main register writes take effect on `arch_regs` together, in the cycle after the final instruction's handshake. Register n occupies bits [8n+7:8n]. Before that cycle, `arch_regs` does not change.
- R8: The instruction word is 18 bits: [17] last, [16:15] op, [14] temp read enable, [13] temp read index, [12] temp write enable, [11] temp write index, [10] main write enable, [9:8] main register index, [7:0] data. The data field is the result value or the memory address. An arithmetic beat is taken only when `iss_ready` is high, and a memory beat only when `ls_ready` is high.
- R9: After reset, no clause is open, all slots and temporaries are free, `arch_regs` is zero and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Clause header offered |
| hdr_ready | output | 1 | Header can be taken (idle) |
| hdr_wait | input | 4 | Slots that must complete before the clause starts |
| ins_valid | input | 1 | Instruction beat offered |
| ins_ready | output | 1 | Instruction beat taken this cycle |
| ins_word | input | 18 | Instruction word, layout in R8 |
| iss_valid | output | 1 | Arithmetic instruction toward the datapath |
| iss_ready | input | 1 | Datapath can take an instruction |
| iss_word | output | 18 | Issued instruction word |
| ls_valid | output | 1 | Memory request offered |
| ls_ready | input | 1 | Memory side can take a request |
| ls_load | output | 1 | Request is a load (1) or a store (0) |
| ls_slot | output | 2 | Slot assigned to the load |
| ls_addr | output | 8 | Request address |
| cmp_valid | input | 1 | A load completed |
| cmp_slot | input | 2 | Slot of the completed load |
| arch_regs | output | 32 | Committed main register values |
| err_temp | output | 1 | Temporary read before written (pulse) |
| err_place | output | 1 | Memory operation inside a clause (pulse) |

## Verification
Routing and readiness (`ins_ready`, `iss_valid`, `ls_valid`, `ls_slot`) are combinational within the cycle a beat is offered. The bench samples them just after it drives the beat, before the accepting edge. The two error flags and `arch_regs` are registered once. They are checked at the falling edge that follows the accepting edge. The wait gate adds two edges after the clearing completion. The mask sweep therefore checks `ins_ready` one full cycle after each completion, and expects it high only when no masked slot remains outstanding.

// File: rtl/clause_pkg.sv
package clause_pkg;
  parameter int DATA_W = 8;
  parameter int NREG   = 4;
  parameter int NTEMP  = 2;
  parameter int NSLOT  = 4;
  localparam int REG_W  = $clog2(NREG);
  localparam int TMP_W  = $clog2(NTEMP);
  localparam int SLOT_W = $clog2(NSLOT);

  typedef enum logic [1:0] {
    OP_ALU   = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_ALT   = 2'd3
  } op_e;

  typedef struct packed {
    logic              last;
    op_e               op;
    logic              rd_tmp;
    logic [TMP_W-1:0]  rd_tidx;
    logic              wr_tmp;
    logic [TMP_W-1:0]  wr_tidx;
    logic              wr_main;
    logic [REG_W-1:0]  wr_ridx;
    logic [DATA_W-1:0] data;
  } ins_t;

  localparam int INS_W = $bits(ins_t);
endpackage

// File: rtl/clause_slot_tracker.sv
module clause_slot_tracker #(
  parameter int NSLOT = 4,
  parameter int SW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic             clr_en,
  input  logic [SW-1:0]    clr_idx,
  output logic [NSLOT-1:0] busy,
  output logic             any_free,
  output logic [SW-1:0]    free_idx
);
  logic [NSLOT-1:0] set_vec, clr_vec;

  always_comb begin
    free_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!busy[i]) free_idx = SW'(i);
    end
    any_free = ~&busy;
    set_vec  = '0;
    clr_vec  = '0;
    if (alloc_en) set_vec[free_idx] = 1'b1;
    if (clr_en)   clr_vec[clr_idx]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= '0;
    else        busy <= (busy & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/clause_temp_board.sv
module clause_temp_board #(
  parameter int NTEMP = 2,
  parameter int TW    = $clog2(NTEMP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_idx,
  input  logic [TW-1:0] rd_idx,
  input  logic          flush,
  output logic          rd_ok
);
  logic [NTEMP-1:0] live;

  assign rd_ok = live[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     live <= '0;
    else if (flush) live <= '0;
    else if (wr_en) live[wr_idx] <= 1'b1;
  end
endmodule

// File: rtl/clause_commit_buf.sv
module clause_commit_buf #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  parameter int RW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic               commit,
  output logic [NREG*DW-1:0] arch_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          pend_v;
    logic [DW-1:0] pend_d;
    logic [DW-1:0] arch_q;
    logic          hit;

    assign hit = wr_en && (wr_idx == RW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_v <= 1'b0;
        pend_d <= '0;
        arch_q <= '0;
      end else if (commit) begin
        if (hit)         arch_q <= wr_data;
        else if (pend_v) arch_q <= pend_d;
        pend_v <= 1'b0;
      end else if (hit) begin
        pend_v <= 1'b1;
        pend_d <= wr_data;
      end
    end

    assign arch_flat[g*DW +: DW] = arch_q;
  end
endmodule

// File: rtl/clause_issue_ctrl.sv
module clause_issue_ctrl
  import clause_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hdr_valid,
  output logic                   hdr_ready,
  input  logic [NSLOT-1:0]       hdr_wait,
  input  logic                   ins_valid,
  output logic                   ins_ready,
  input  logic [INS_W-1:0]       ins_word,
  output logic                   iss_valid,
  input  logic                   iss_ready,
  output logic [INS_W-1:0]       iss_word,
  output logic                   ls_valid,
  input  logic                   ls_ready,
  output logic                   ls_load,
  output logic [SLOT_W-1:0]      ls_slot,
  output logic [DATA_W-1:0]      ls_addr,
  input  logic                   cmp_valid,
  input  logic [SLOT_W-1:0]      cmp_slot,
  output logic [NREG*DATA_W-1:0] arch_regs,
  output logic                   err_temp,
  output logic                   err_place
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} st_e;

  st_e              st;
  logic [NSLOT-1:0] wait_r;
  logic             first_q;
  ins_t             ins;
  logic             in_run, in_wait;
  logic             is_mem, is_load, misplaced, dep_clear;
  logic             fire, alu_fire, load_fire, clause_end;
  logic [NSLOT-1:0] slot_busy;
  logic             slot_any_free;
  logic [SLOT_W-1:0] slot_free_idx;
  logic             tmp_rd_ok, tmp_bad;

  assign ins       = ins_t'(ins_word);
  assign in_run    = (st == ST_RUN);
  assign in_wait   = (st == ST_WAIT);
  assign hdr_ready = (st == ST_IDLE);
  assign is_load   = (ins.op == OP_LOAD);
  assign is_mem    = is_load || (ins.op == OP_STORE);
  assign misplaced = is_mem && !first_q && !ins.last;
  assign dep_clear = ((slot_busy & wait_r) == '0);

  // beat routing: arithmetic to the datapath, edge memory ops to the request port
  always_comb begin
    iss_valid = 1'b0;
    ls_valid  = 1'b0;
    ins_ready = 1'b0;
    if (in_run && ins_valid) begin
      if (misplaced) begin
        ins_ready = 1'b1;
      end else if (is_mem) begin
        ls_valid  = !is_load || slot_any_free;
        ins_ready = ls_valid && ls_ready;
      end else begin
        iss_valid = 1'b1;
        ins_ready = iss_ready;
      end
    end
  end

  assign iss_word = ins_word;
  assign ls_load  = is_load;
  assign ls_slot  = slot_free_idx;
  assign ls_addr  = ins.data;

  assign fire       = ins_valid && ins_ready;
  assign alu_fire   = fire && !is_mem;
  assign load_fire  = fire && is_load && !misplaced;
  assign clause_end = fire && ins.last;
  assign tmp_bad    = alu_fire && ins.rd_tmp && !tmp_rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wait_r    <= '0;
      first_q   <= 1'b0;
      err_temp  <= 1'b0;
      err_place <= 1'b0;
    end else begin
      err_temp  <= tmp_bad;
      err_place <= fire && misplaced;
      unique case (st)
        ST_IDLE: if (hdr_valid) begin
          wait_r <= hdr_wait;
          st     <= ST_WAIT;
        end
        ST_WAIT: if (dep_clear) begin
          first_q <= 1'b1;
          st      <= ST_RUN;
        end
        ST_RUN: if (fire) begin
          first_q <= 1'b0;
          if (ins.last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  clause_slot_tracker #(.NSLOT(NSLOT), .SW(SLOT_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (load_fire),
    .clr_en   (cmp_valid),
    .clr_idx  (cmp_slot),
    .busy     (slot_busy),
    .any_free (slot_any_free),
    .free_idx (slot_free_idx)
  );

  clause_temp_board #(.NTEMP(NTEMP), .TW(TMP_W)) u_temps (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (alu_fire && ins.wr_tmp),
    .wr_idx (ins.wr_tidx),
    .rd_idx (ins.rd_tidx),
    .flush  (clause_end),
    .rd_ok  (tmp_rd_ok)
  );

  clause_commit_buf #(.NREG(NREG), .DW(DATA_W), .RW(REG_W)) u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (alu_fire && ins.wr_main),
    .wr_idx    (ins.wr_ridx),
    .wr_data   (ins.data),
    .commit    (clause_end),
    .arch_flat (arch_regs)
  );
endmodule

// File: rtl/clause_issue_checks.sv
module clause_issue_checks
  import clause_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   hdr_ready,
  input logic                   ins_valid,
  input logic                   ins_ready,
  input logic [INS_W-1:0]       ins_word,
  input logic                   iss_valid,
  input logic                   ls_valid,
  input logic                   ls_load,
  input logic [SLOT_W-1:0]      ls_slot,
  input logic [NREG*DATA_W-1:0] arch_regs,
  input logic                   err_temp,
  input logic                   err_place,
  input logic [NSLOT-1:0]       slot_busy,
  input logic [NSLOT-1:0]       wait_mask,
  input logic                   in_run,
  input logic                   in_wait
);
  ins_t w;
  assign w = ins_t'(ins_word);

  assert_hdr_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |-> !hdr_ready);

  assert_dep_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && $past(in_wait)) |-> $past((slot_busy & wait_mask) == '0));

  assert_free_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_valid && ls_load) |-> !slot_busy[ls_slot]);

  assert_place_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_place |-> $past(ins_valid && ins_ready && !w.last));

  assert_temp_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_temp |-> $past(ins_valid && ins_ready && w.rd_tmp));

  assert_arch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ins_valid && ins_ready && w.last) |-> $stable(arch_regs));

  assert_one_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && ls_valid));
endmodule

bind clause_issue_ctrl clause_issue_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_ready (hdr_ready),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .ins_word  (ins_word),
  .iss_valid (iss_valid),
  .ls_valid  (ls_valid),
  .ls_load   (ls_load),
  .ls_slot   (ls_slot),
  .arch_regs (arch_regs),
  .err_temp  (err_temp),
  .err_place (err_place),
  .slot_busy (slot_busy),
  .wait_mask (wait_r),
  .in_run    (in_run),
  .in_wait   (in_wait)
);

// File: tb/clause_issue_ctrl_test.sv
module clause_issue_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [3:0]  hdr_wait = '0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [17:0] ins_word = '0;
  logic        iss_valid;
  logic        iss_ready = 1'b1;
  logic [17:0] iss_word;
  logic        ls_valid;
  logic        ls_ready = 1'b1;
  logic        ls_load;
  logic [1:0]  ls_slot;
  logic [7:0]  ls_addr;
  logic        cmp_valid = 1'b0;
  logic [1:0]  cmp_slot = '0;
  logic [31:0] arch_regs;
  logic        err_temp, err_place;

  int n_chk = 0;
  int n_fail = 0;
  logic s_ok, s_iss, s_ls, s_load;
  logic [1:0] s_slot;

  always #5 clk = ~clk;

  clause_issue_ctrl uut (.*);

  function automatic logic [17:0] mk(input bit last, input bit [1:0] op,
      input bit rdt, input bit rti, input bit wrt, input bit wti,
      input bit wm, input bit [1:0] wri, input bit [7:0] d);
    return {last, op, rdt, rti, wrt, wti, wm, wri, d};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_hdr(input logic [3:0] m);
    hdr_valid = 1'b1;
    hdr_wait  = m;
    #1;
    while (!hdr_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic send_ins(input logic [17:0] w);
    ins_valid = 1'b1;
    ins_word  = w;
    #1;
    for (int n = 0; n < 20 && !ins_ready; n++) begin @(negedge clk); #1; end
    s_ok = ins_ready; s_iss = iss_valid; s_ls = ls_valid;
    s_load = ls_load; s_slot = ls_slot;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic complete(input int s);
    cmp_valid = 1'b1;
    cmp_slot  = 2'(s);
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] remaining;
    bit started;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ins_valid = 1'b1; ins_word = mk(1, 0, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R9 hdr_ready", hdr_ready, 1);
    chk("R9 ins_ready", ins_ready, 0);
    chk("R9 arch", arch_regs, 0);
    chk("R9 errors", {err_temp, err_place}, 0);
    @(negedge clk);
    ins_valid = 1'b0;

    // clause with a leading load, temporaries and buffered writes
    send_hdr(4'h0);
    send_ins(mk(0, 1, 0, 0, 0, 0, 0, 0, 8'h10));
    chk("R4 load to port", {s_ok, s_ls, s_load, s_iss}, 4'b1110);
    chk("R4 first slot", s_slot, 0);
    #1 chk("R1 hdr closed", hdr_ready, 0);
    send_ins(mk(0, 0, 0, 0, 1, 0, 0, 0, 8'h11));
    chk("R8 alu issue", {s_iss, s_ls}, 2'b10);
    send_ins(mk(0, 0, 1, 0, 0, 0, 1, 1, 8'h55));
    chk("R6 written temp ok", err_temp, 0);
    chk("R7 no early commit", arch_regs, 0);
    send_ins(mk(0, 0, 1, 1, 0, 0, 1, 2, 8'h66));
    chk("R6 unwritten temp", err_temp, 1);
    send_ins(mk(0, 2, 0, 0, 0, 0, 0, 0, 8'h30));
    chk("R5 dropped mid store", {s_ok, s_ls, s_iss}, 3'b100);
    chk("R5 err_place", err_place, 1);
    chk("R7 still held", arch_regs, 0);
    send_ins(mk(1, 0, 0, 0, 0, 0, 1, 3, 8'h77));
    chk("R7 commit", arch_regs, 32'h77665500);
    chk("R1 reopen", hdr_ready, 1);

    // temporaries do not survive the clause
    send_hdr(4'h0);
    send_ins(mk(1, 0, 1, 0, 0, 0, 0, 0, 8'h00));
    chk("R6 temp flushed", err_temp, 1);
    complete(0);

    // back-pressure from the datapath
    iss_ready = 1'b0;
    send_hdr(4'h0);
    ins_valid = 1'b1; ins_word = mk(1, 0, 0, 0, 0, 0, 1, 0, 8'h99);
    repeat (3) @(negedge clk);
    #1 chk("R8 stalled by iss_ready", ins_ready, 0);
    iss_ready = 1'b1;
    #1 chk("R8 released", ins_ready, 1);
    @(negedge clk);
    ins_valid = 1'b0;
    chk("R7 commit r0", arch_regs, 32'h77665599);

    // store at clause start takes no slot
    send_hdr(4'h0);
    send_ins(mk(1, 2, 0, 0, 0, 0, 0, 0, 8'h20));
    chk("R4 store", {s_ls, s_load}, 2'b10);
    chk("R5 edge store legal", err_place, 0);

    // fill every slot, then a load must wait
    for (int j = 0; j < 4; j++) begin
      send_hdr(4'h0);
      send_ins(mk(1, 1, 0, 0, 0, 0, 0, 0, 8'(j)));
      chk("R4 lowest free slot", s_slot, j);
    end
    send_hdr(4'h0);
    ins_valid = 1'b1; ins_word = mk(1, 1, 0, 0, 0, 0, 0, 0, 8'h40);
    repeat (2) @(negedge clk);
    #1 chk("R4 no free slot", {ins_ready, ls_valid}, 2'b00);
    complete(2);
    #1 chk("R3 slot 2 freed", {ls_valid, ls_slot}, 3'b110);
    @(negedge clk);
    ins_valid = 1'b0;
    for (int j = 0; j < 4; j++) complete(j);

    // wait-mask sweep with completions in reverse order
    for (int m = 1; m < 16; m++) begin
      for (int j = 0; j < 4; j++) begin
        send_hdr(4'h0);
        send_ins(mk(1, 1, 0, 0, 0, 0, 0, 0, 8'(j)));
        chk("R4 sweep slot", s_slot, j);
      end
      send_hdr(4'(m));
      ins_valid = 1'b1; ins_word = mk(1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
      #1 chk("R2 stalled at start", ins_ready, 0);
      remaining = 4'hF;
      started = 0;
      for (int k = 3; k >= 0; k--) begin
        complete(k);
        remaining[k] = 1'b0;
        if (!started) begin
          @(negedge clk);
          #1 chk("R2 R3 gate", ins_ready, ((4'(m) & remaining) == 0));
          if (ins_ready) begin
            started = 1;
            @(negedge clk);
            ins_valid = 1'b0;
          end
        end
      end
      ins_valid = 1'b0;
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule